// File: doc/BRIEF.md
# Exception Cause Register with Gated Cycle Counter

This block holds a 32-bit exception cause word that software can update through a masked write port, together with a free-running 32-bit cycle counter whose progress the cause word controls. Only five bits of the cause word accept software data: two software interrupt request bits, the watch-pending flag, the interrupt-vector select, and a count-stop bit whose write access depends on the architecture revision. Every other bit keeps its value across writes. The two software interrupt bits drive interrupt request outputs that change only when a write actually flips the matching bit.

The count-stop bit freezes the counter while it is set and lets it run again once it is cleared. The counter has its own load port. Two strap-like inputs select the revision behaviour: one makes the count-stop bit writable, and the other turns the watch-pending flag into a clear-only bit.

Top module: `cause_count_top`

## Requirements
- R1: While rst_ni is low, cause_o, swi_o and count_o are all zero.
- R2: A cause write changes only bits 8 (soft request 0), 9 (soft request 1), 22 (watch pending) and 23 (vector select), plus bit 27 under R3. All other bits of cause_o stay zero.
- R3: Bit 27 (count stop) takes the written value only when rev2_i is 1. When rev2_i is 0 it keeps its old value.
- R4: When rev6_i is 1, a write with data bit 22 set leaves bit 22 unchanged, and a write with data bit 22 clear clears it. When rev6_i is 0, bit 22 takes the written value.
- R5: Each write produces (old AND NOT mask) OR (data AND mask), with the mask formed as in R2 to R4. With cause_we_i low, cause_o holds its value.
- R6: swi_o[i] takes the new value of cause bit 8+i on a write that changes that bit. A write that leaves the bit unchanged leaves swi_o[i] unchanged.
- R7: While cause bit 27 is 0 and no count load is requested, count_o increases by one on each clock edge.
- R8: While cause bit 27 is 1, count_o holds its value. Counting restarts on the first edge after bit 27 returns to 0.
- R9: When count_we_i is 1, count_o takes count_wdata_i on the next edge. This load wins over incrementing and also takes effect while counting is stopped.
- R10: Incrementing past 0xFFFFFFFF wraps count_o to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rev2_i | input | 1 | Makes the count-stop bit writable |
| rev6_i | input | 1 | Makes the watch-pending flag clear-only |
| cause_we_i | input | 1 | Cause write strobe |
| cause_wdata_i | input | 32 | Cause write data |
| count_we_i | input | 1 | Counter load strobe |
| count_wdata_i | input | 32 | Counter load value |
| cause_o | output | 32 | Current cause word |
| swi_o | output | 2 | Software interrupt requests |
| count_o | output | 32 | Current count |

## Verification
All-ones cause writes under each combination of rev2_i and rev6_i separate the four mask variants: the base bits only, with count stop added, with watch pending made clear-only, and both together. Setting the watch-pending flag and then writing it with rev6_i high shows whether set and clear are treated differently. A random phase mixes cause writes with repeated and flipped soft request bits, which tests whether swi_o reacts to changes or to writes. Counter loads near 0xFFFFFFFF, with the counter both running and stopped, exercise the wrap, the load priority and the one-edge lag of the stop bit.

// File: rtl/cause_pkg.sv
package cause_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned SWI_N   = 2;
  localparam int unsigned IP_LSB  = 8;
  localparam int unsigned WP_BIT  = 22;
  localparam int unsigned IV_BIT  = 23;
  localparam int unsigned DC_BIT  = 27;
  localparam logic [DATA_W-1:0] BASE_MASK = (DATA_W'(3) << IP_LSB)
                                          | (DATA_W'(1) << WP_BIT)
                                          | (DATA_W'(1) << IV_BIT);
  localparam logic [DATA_W-1:0] DC_MASK = DATA_W'(1) << DC_BIT;
  localparam logic [DATA_W-1:0] WP_MASK = DATA_W'(1) << WP_BIT;
endpackage

// File: rtl/cause_reg.sv
module cause_reg
  import cause_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rev2_i,
  input  logic              rev6_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] q_o,
  output logic [DATA_W-1:0] d_o
);
  logic [DATA_W-1:0] wmask;
  logic [DATA_W-1:0] q;

  always_comb begin
    wmask = BASE_MASK;
    if (rev2_i) wmask = wmask | DC_MASK;
    // clear-only flag: a written 1 drops the bit from the mask
    if (rev6_i) wmask = wmask & ~(WP_MASK & wdata_i);
    d_o = we_i ? ((q & ~wmask) | (wdata_i & wmask)) : q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= d_o;
  end

  assign q_o = q;
endmodule

// File: rtl/swi_ctrl.sv
module swi_ctrl #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [N-1:0] old_i,
  input  logic [N-1:0] new_i,
  output logic [N-1:0] irq_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic irq_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          irq_q <= 1'b0;
      else if (we_i && (old_i[g] != new_i[g])) irq_q <= new_i[g];
    end
    assign irq_o[g] = irq_q;
  end
endmodule

// File: rtl/count_reg.sv
module count_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         stop_i,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= '0;
    else if (we_i)   q <= wdata_i;
    else if (!stop_i) q <= q + W'(1);
  end

  assign q_o = q;
endmodule

// File: rtl/cause_count_top.sv
module cause_count_top
  import cause_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rev2_i,
  input  logic              rev6_i,
  input  logic              cause_we_i,
  input  logic [DATA_W-1:0] cause_wdata_i,
  input  logic              count_we_i,
  input  logic [CNT_W-1:0]  count_wdata_i,
  output logic [DATA_W-1:0] cause_o,
  output logic [SWI_N-1:0]  swi_o,
  output logic [CNT_W-1:0]  count_o
);
  logic [DATA_W-1:0] cause_q, cause_d;

  cause_reg i_cause (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rev2_i  (rev2_i),
    .rev6_i  (rev6_i),
    .we_i    (cause_we_i),
    .wdata_i (cause_wdata_i),
    .q_o     (cause_q),
    .d_o     (cause_d)
  );

  swi_ctrl #(.N(SWI_N)) i_swi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cause_we_i),
    .old_i  (cause_q[IP_LSB +: SWI_N]),
    .new_i  (cause_d[IP_LSB +: SWI_N]),
    .irq_o  (swi_o)
  );

  count_reg #(.W(CNT_W)) i_count (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .stop_i  (cause_q[DC_BIT]),
    .we_i    (count_we_i),
    .wdata_i (count_wdata_i),
    .q_o     (count_o)
  );

  assign cause_o = cause_q;
endmodule

// File: rtl/cause_count_chk.sv
module cause_count_chk
  import cause_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rev2_i,
  input logic              rev6_i,
  input logic              cause_we_i,
  input logic              count_we_i,
  input logic [CNT_W-1:0]  count_wdata_i,
  input logic [DATA_W-1:0] cause_o,
  input logic [SWI_N-1:0]  swi_o,
  input logic [CNT_W-1:0]  count_o
);
  localparam logic [DATA_W-1:0] ALL_MASK = BASE_MASK | DC_MASK;

  AST_RO_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_o & ~ALL_MASK) == '0); // R2
  AST_DC_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_we_i && !rev2_i) |=> $stable(cause_o[DC_BIT])); // R3
  AST_WP_NO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_we_i && rev6_i) |=> !$rose(cause_o[WP_BIT])); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cause_we_i |=> $stable(cause_o)); // R5
  AST_SWI_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swi_o == cause_o[IP_LSB +: SWI_N]); // R6
  AST_COUNT_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cause_o[DC_BIT] && !count_we_i) |=> count_o == $past(count_o) + CNT_W'(1)); // R7
  AST_COUNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_o[DC_BIT] && !count_we_i) |=> $stable(count_o)); // R8
  AST_COUNT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_we_i |=> count_o == $past(count_wdata_i)); // R9
endmodule

bind cause_count_top cause_count_chk #(.CNT_W(CNT_W)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .rev2_i        (rev2_i),
  .rev6_i        (rev6_i),
  .cause_we_i    (cause_we_i),
  .count_we_i    (count_we_i),
  .count_wdata_i (count_wdata_i),
  .cause_o       (cause_o),
  .swi_o         (swi_o),
  .count_o       (count_o)
);

// File: tb/test_cause_count_top.sv
`timescale 1ns/1ps
module test_cause_count_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rev2 = 1'b0, rev6 = 1'b0;
  logic        c_we = 1'b0, n_we = 1'b0;
  logic [31:0] c_wd = '0, n_wd = '0;
  logic [31:0] cause;
  logic [1:0]  swi;
  logic [31:0] count;

  logic [31:0] m_cause, m_cnt;
  logic [1:0]  m_swi;
  int n_chk = 0, n_fail = 0, cyc = 0;
  bit  done = 0;

  always #2.5 clk = ~clk;

  cause_count_top i_cause_count_top (
    .clk_i(clk), .rst_ni(rst_n), .rev2_i(rev2), .rev6_i(rev6),
    .cause_we_i(c_we), .cause_wdata_i(c_wd),
    .count_we_i(n_we), .count_wdata_i(n_wd),
    .cause_o(cause), .swi_o(swi), .count_o(count)
  );

  function automatic logic [31:0] wmask(logic r2, logic r6, logic [31:0] d);
    logic [31:0] m;
    m = 32'h00C0_0300;                 // R2: bits 8,9,22,23
    if (r2) m |= 32'h0800_0000;        // R3: bit 27
    if (r6) m &= ~(32'h0040_0000 & d); // R4: bit 22 clear-only
    return m;
  endfunction

  function automatic logic [31:0] next_cause(logic [31:0] o, logic r2, logic r6, logic [31:0] d);
    logic [31:0] m;
    m = wmask(r2, r6, d);
    return (o & ~m) | (d & m);         // R5
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cause <= '0; m_swi <= '0; m_cnt <= '0;
    end else begin
      logic [31:0] nc;
      nc = c_we ? next_cause(m_cause, rev2, rev6, c_wd) : m_cause;
      m_cause <= nc;
      for (int i = 0; i < 2; i++)
        if (c_we && (nc[8+i] != m_cause[8+i])) m_swi[i] <= nc[8+i]; // R6
      if (n_we)              m_cnt <= n_wd;            // R9
      else if (!m_cause[27]) m_cnt <= m_cnt + 32'd1;   // R7 R8 R10
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tc, string ts, string tn);
    chk(tc, cause, m_cause);
    chk(ts, {30'd0, swi}, {30'd0, m_swi});
    chk(tn, count, m_cnt);
  endtask

  task automatic step(logic we, logic [31:0] wd, logic r2, logic r6,
                      logic nwe, logic [31:0] nwd, string tc, string ts, string tn);
    c_we = we; c_wd = wd; rev2 = r2; rev6 = r6; n_we = nwe; n_wd = nwd;
    @(negedge clk);
    check_all(tc, ts, tn);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected under 100000", cyc);
      summary();
    end
  end

  initial begin
    logic [31:0] s;
    s = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    chk("R1 cause", cause, 32'h0);
    chk("R1 swi", {30'd0, swi}, 32'h0);
    chk("R1 count", count, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1", "R1", "R7");

    step(1, 32'hFFFF_FFFF, 0, 0, 0, 0, "R2 R3", "R6", "R7");
    chk("R2 literal", cause, 32'h00C0_0300);
    chk("R6 literal", {30'd0, swi}, 32'h3);
    step(1, 32'hFFFF_FFFF, 0, 0, 0, 0, "R5", "R6 unchanged", "R7");
    step(1, 32'hFFFF_FFFF, 0, 1, 0, 0, "R4 set blocked", "R6", "R7");
    step(1, 32'h0000_0200, 0, 1, 0, 0, "R4 clear", "R6", "R7");
    chk("R4 literal", cause, 32'h0000_0200);
    step(1, 32'h0040_0200, 0, 1, 0, 0, "R4 no set", "R6", "R7");
    step(1, 32'h0840_0100, 1, 0, 0, 0, "R3 R4", "R6", "R7");
    chk("R3 literal", cause, 32'h0840_0100);
    step(0, 0, 0, 0, 0, 0, "R5", "R6", "R8 hold");
    step(0, 0, 0, 0, 0, 0, "R5", "R6", "R8 hold");
    step(1, 32'h0000_0000, 0, 0, 0, 0, "R3 locked", "R6", "R8");
    step(0, 0, 0, 0, 1, 32'h1234_5678, "R5", "R6", "R9 load stopped");
    step(1, 32'h0000_0000, 1, 0, 0, 0, "R3 clear", "R6", "R8");
    step(0, 0, 0, 0, 0, 0, "R5", "R6", "R8 resume");
    step(0, 0, 0, 0, 1, 32'hFFFF_FFFE, "R5", "R6", "R9");
    step(0, 0, 0, 0, 0, 0, "R5", "R6", "R7");
    step(0, 0, 0, 0, 0, 0, "R5", "R6", "R10 wrap");
    chk("R10 literal", count, 32'h0);

    for (int k = 0; k < 600; k++) begin
      logic [31:0] d, nd;
      logic we, nwe;
      we  = ($urandom % 3) == 0;
      d   = $urandom;
      nwe = ($urandom % 20) == 0;
      nd  = (($urandom % 2) == 0) ? (32'hFFFF_FFF0 | ($urandom % 16)) : $urandom;
      step(we, d, $urandom % 2, $urandom % 2, nwe, nd,
           "R2 R3 R4 R5", "R6", "R7 R8 R9 R10");
    end
    c_we = 0; n_we = 0;
    summary();
  end
endmodule